// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block sits beside a processor core. It collects ten interrupt levels and picks the most urgent one that is allowed to run. It then presents a request to the sequencer, together with the byte address of that level's entry in a vector table that starts at local address 0. Raw source lines are edge-detected into pending bits. Software can write a mask bit for each level and can turn a global enable on or off. The global enable covers every level except the top one, which is the synchronization/reset level.

Nesting is tracked with an in-service bit vector. When the sequencer accepts a request, that level moves from pending to in service. A later level may only interrupt the running handler if it outranks every level already in service. A return-from-interrupt strobe retires the most urgent in-service level, so nested handlers unwind in the right order. Executing handlers, saving context and the blocks that raise the sources are outside this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req_o` is 0, `vec_addr_o` is 0 and `in_service_o` is 0. All mask bits are clear, the global enable is off, no level is pending, and the stored previous value of every line is 0.
- R2: A 0-to-1 change on `irq_line_i[i]` makes level i pending. A line held high raises nothing more once its pending bit has been taken; it needs a new rising edge. A rise in the same cycle as that level is taken leaves the level pending.
- R3: Level 3 is a reserved slot. Its input line is ignored, it never requests and it never enters service.
- R4: A `mask_wr_i` strobe loads all ten mask bits from `mask_data_i`; bit i set blocks level i. A masked level stays pending and requests once it is unmasked.
- R5: `gie_set_i` turns the global enable on and `gie_clr_i` turns it off; when both strobe in one cycle, clear wins. While the enable is off, only level 0 can request.
- R6: The levels are 0 sync/reset, 1 software exception, 2 memory fault, 3 reserved, 4 timer0, 5 timer1, 6 DMA0, 7 DMA1, 8 wired-AND, 9 user. Among the eligible levels, the lowest index wins. While a request is up, `vec_addr_o` = index × 4; with no request it is 0.
- R7: A request is raised only if the winning index is strictly lower than every index set in `in_service_o`.
- R8: `ack_i` during a request clears that level's pending bit and sets its `in_service_o` bit at the same edge.
- R9: `rti_i` clears only the lowest-index set bit of `in_service_o`. With no bit set, it has no effect.
- R10: `ack_i` while no request is up has no effect.
- R11: An accepted preemption adds its bit to `in_service_o` and keeps the earlier bits. Successive `rti_i` strobes then retire the levels from most to least urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | 10 | Raw interrupt source lines, bit = level |
| mask_wr_i | input | 1 | Load mask register |
| mask_data_i | input | 10 | New mask value, 1 = blocked |
| gie_set_i | input | 1 | Turn global enable on |
| gie_clr_i | input | 1 | Turn global enable off |
| ack_i | input | 1 | Sequencer takes the current request |
| rti_i | input | 1 | Return from interrupt |
| irq_req_o | output | 1 | Interrupt request to the sequencer |
| vec_addr_o | output | VADDR_W (16) | Vector table byte address |
| in_service_o | output | 10 | Levels currently in service |

## Verification
The bench builds the block with its defaults: a 16-bit vector address and a shift of 2, so entries sit 4 bytes apart. This places the user level at 36 and puts every table address within reach of the output width. With ten fixed levels, each slot, including the reserved one, can be driven directly. Directed sequences cover three-deep nesting, masking, the enable gate and strobe collisions. A long stretch of random line, mask, acknowledge and return traffic then reaches mixed in-service stacks that a directed list would miss.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int LVL_N = 10;
    localparam int IDX_W = $clog2(LVL_N);

    typedef enum logic [IDX_W-1:0] {
        LV_SYNC   = 4'd0,
        LV_SWEXC  = 4'd1,
        LV_MEMFLT = 4'd2,
        LV_RSVD   = 4'd3,
        LV_TMR0   = 4'd4,
        LV_TMR1   = 4'd5,
        LV_DMA0   = 4'd6,
        LV_DMA1   = 4'd7,
        LV_WAND   = 4'd8,
        LV_USER   = 4'd9
    } lvl_e;

    typedef logic [LVL_N-1:0] lvl_vec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Lowest set index wins (index 0 is most urgent).
    function automatic pick_t first_set(lvl_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = LVL_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t idx_bit(logic [IDX_W-1:0] idx);
        lvl_vec_t b;
        b = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (IDX_W'(i) == idx) b[i] = 1'b1;
        end
        return b;
    endfunction

    // Bits 0..idx set.
    function automatic lvl_vec_t upto_mask(logic [IDX_W-1:0] idx);
        lvl_vec_t b;
        b = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (IDX_W'(i) <= idx) b[i] = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/nic_pend_latch.sv
module nic_pend_latch
    import nic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t raw_i,
    input  lvl_vec_t clr_i,
    output lvl_vec_t pend_o
);

    lvl_vec_t prev_q;
    lvl_vec_t pend_q;

    for (genvar g = 0; g < LVL_N; g++) begin : g_bit
        if (g == int'(LV_RSVD)) begin : g_rsvd
            always_ff @(posedge clk) begin
                if (rst) prev_q[g] <= 1'b0;
                else     prev_q[g] <= raw_i[g];
                pend_q[g] <= 1'b0;
            end
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q[g] <= 1'b0;
                    pend_q[g] <= 1'b0;
                end else begin
                    prev_q[g] <= raw_i[g];
                    pend_q[g] <= (pend_q[g] & ~clr_i[g]) | (raw_i[g] & ~prev_q[g]);
                end
            end

            // R2: a rising edge always leaves the level pending
            assert_edge_latch_R2: assert property (@(posedge clk) disable iff (rst)
                (raw_i[g] && !prev_q[g]) |=> pend_q[g]);
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
(
    input  lvl_vec_t         pend_i,
    input  lvl_vec_t         mask_i,
    input  logic             gie_i,
    input  lvl_vec_t         isr_i,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o
);

    lvl_vec_t elig;
    lvl_vec_t gate;
    pick_t    win;
    pick_t    top;

    always_comb begin
        gate       = gie_i ? '1 : '0;
        gate[LV_SYNC] = 1'b1;
        elig       = pend_i & ~mask_i & gate;
        win        = first_set(elig);
        top        = first_set(isr_i);
        req_o      = win.hit && (!top.hit || (win.idx < top.idx));
        idx_o      = win.idx;
    end

endmodule

// File: rtl/nic_nest_track.sv
module nic_nest_track
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en_i,
    input  logic [IDX_W-1:0] set_idx_i,
    input  logic             rti_i,
    output lvl_vec_t         isr_o
);

    lvl_vec_t isr_q;
    lvl_vec_t clr_v;
    lvl_vec_t set_v;
    pick_t    top;

    always_comb begin
        top   = first_set(isr_q);
        clr_v = (rti_i && top.hit) ? idx_bit(top.idx) : '0;
        set_v = set_en_i ? idx_bit(set_idx_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~clr_v) | set_v;
    end

    assign isr_o = isr_q;

    // R8: a taken level is in service on the next cycle
    assert_take_sets_R8: assert property (@(posedge clk) disable iff (rst)
        set_en_i |=> isr_q[$past(set_idx_i)]);

    // R9: one return retires exactly one level
    assert_rti_pops_R9: assert property (@(posedge clk) disable iff (rst)
        (rti_i && !set_en_i && (isr_q != '0)) |=>
            ($countones(isr_q) == $past($countones(isr_q)) - 1));

    // R11: a preemption stacks on top of existing levels
    assert_nest_push_R11: assert property (@(posedge clk) disable iff (rst)
        (set_en_i && !rti_i) |=>
            ($countones(isr_q) == $past($countones(isr_q)) + 1));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int VADDR_W   = 16,
    parameter int VEC_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_N-1:0]     irq_line_i,
    input  logic                 mask_wr_i,
    input  logic [LVL_N-1:0]     mask_data_i,
    input  logic                 gie_set_i,
    input  logic                 gie_clr_i,
    input  logic                 ack_i,
    input  logic                 rti_i,
    output logic                 irq_req_o,
    output logic [VADDR_W-1:0]   vec_addr_o,
    output logic [LVL_N-1:0]     in_service_o
);

    localparam logic [VADDR_W-1:0] VEC_ZERO = '0;

    lvl_vec_t         mask_q;
    logic             gie_q;
    lvl_vec_t         pend;
    lvl_vec_t         isr;
    lvl_vec_t         take_clr;
    logic             req;
    logic [IDX_W-1:0] win_idx;
    logic             take;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (mask_wr_i) mask_q <= mask_data_i;
            if (gie_clr_i)      gie_q <= 1'b0;
            else if (gie_set_i) gie_q <= 1'b1;
        end
    end

    assign take     = req && ack_i;
    assign take_clr = take ? idx_bit(win_idx) : '0;

    nic_pend_latch u_pend (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (irq_line_i),
        .clr_i  (take_clr),
        .pend_o (pend)
    );

    nic_arbiter u_arb (
        .pend_i (pend),
        .mask_i (mask_q),
        .gie_i  (gie_q),
        .isr_i  (isr),
        .req_o  (req),
        .idx_o  (win_idx)
    );

    nic_nest_track u_nest (
        .clk       (clk),
        .rst       (rst),
        .set_en_i  (take),
        .set_idx_i (win_idx),
        .rti_i     (rti_i),
        .isr_o     (isr)
    );

    assign irq_req_o    = req;
    assign vec_addr_o   = req ? (VADDR_W'(win_idx) << VEC_SHIFT) : VEC_ZERO;
    assign in_service_o = isr;

    // R7: request only when it outranks everything in service
    assert_outranks_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> ((in_service_o & upto_mask(win_idx)) == '0));

    // R5: with the enable off only the top level reaches the sequencer
    assert_gie_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_req_o && !gie_q) |-> (vec_addr_o == VEC_ZERO));

    // R4: a masked level never requests
    assert_mask_block_R4: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> !mask_q[win_idx]);

    // R3: reserved slot never in service
    assert_rsvd_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !in_service_o[LV_RSVD]);

    // R10: a stray acknowledge changes nothing in service
    assert_stray_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_req_o && !rti_i) |=> $stable(in_service_o));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;

    localparam int N = 10;
    localparam int RSV = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_line_i = '0;
    logic          mask_wr_i = 1'b0;
    logic [N-1:0]  mask_data_i = '0;
    logic          gie_set_i = 1'b0;
    logic          gie_clr_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          rti_i = 1'b0;
    logic          irq_req_o;
    logic [15:0]   vec_addr_o;
    logic [N-1:0]  in_service_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit m_pend[N];
    bit m_isr[N];
    bit m_mask[N];
    bit m_prev[N];
    bit m_gie;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_line_i(irq_line_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
        .ack_i(ack_i), .rti_i(rti_i), .irq_req_o(irq_req_o),
        .vec_addr_o(vec_addr_o), .in_service_o(in_service_o)
    );

    function automatic int m_win();
        for (int i = 0; i < N; i++)
            if (m_pend[i] && !m_mask[i] && (m_gie || i == 0)) return i;
        return -1;
    endfunction

    function automatic int m_top();
        for (int i = 0; i < N; i++)
            if (m_isr[i]) return i;
        return -1;
    endfunction

    function automatic bit m_req();
        int w, t;
        w = m_win();
        t = m_top();
        return (w >= 0) && (t < 0 || w < t);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_isr[i] = 0; m_mask[i] = 0; m_prev[i] = 0;
        end
        m_gie = 0;
    endtask

    task automatic compare(string tag);
        bit          e_req;
        logic [15:0] e_vec;
        logic [N-1:0] e_isr;
        e_req = m_req();
        e_vec = e_req ? 16'(m_win() * 4) : 16'd0;
        for (int i = 0; i < N; i++) e_isr[i] = m_isr[i];
        n_chk++;
        if (irq_req_o !== e_req || vec_addr_o !== e_vec || in_service_o !== e_isr) begin
            n_bad++;
            $display("FAIL %s: req/vec/isr actual %b/%0d/%b expected %b/%0d/%b",
                     tag, irq_req_o, vec_addr_o, in_service_o, e_req, e_vec, e_isr);
        end
    endtask

    // One cycle: check outputs, drive inputs, advance model past the edge.
    task automatic step(logic [N-1:0] lines, bit mwr, logic [N-1:0] mdat,
                        bit gs, bit gc, bit ak, bit rt, string tag);
        int w, t;
        bit tk;
        @(negedge clk);
        compare(tag);
        irq_line_i = lines; mask_wr_i = mwr; mask_data_i = mdat;
        gie_set_i = gs; gie_clr_i = gc; ack_i = ak; rti_i = rt;
        w  = m_win();
        t  = m_top();
        tk = m_req() && ak;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            bit rise;
            rise = lines[i] && !m_prev[i] && (i != RSV);
            if (tk && i == w) m_pend[i] = 0;
            if (rise) m_pend[i] = 1;
            m_prev[i] = lines[i];
            if (mwr) m_mask[i] = mdat[i];
        end
        if (rt && t >= 0) m_isr[t] = 0;
        if (tk) m_isr[w] = 1;
        if (gc) m_gie = 0;
        else if (gs) m_gie = 1;
    endtask

    task automatic idle(string tag);
        step(irq_line_i, 0, '0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        idle("R1 reset state");

        // R5: enable off, user level pending but no request
        step(10'b10_0000_0000, 0, '0, 0, 0, 0, 0, "R5 gie off blocks user");
        idle("R5 gie off blocks user");
        step(10'b10_0000_0000, 0, '0, 1, 0, 0, 0, "R5 enable on");
        idle("R6 user vector 36");
        // R10 stray ack when request up is real; first stray ack test later
        step(10'b10_0000_0000, 0, '0, 0, 0, 1, 0, "R8 take user");
        idle("R8 user in service");
        // R2: held-high line does not re-latch
        idle("R2 held line no relatch");
        // R11: timer0 preempts
        step(10'b10_0001_0000, 0, '0, 0, 0, 0, 0, "R11 timer0 raise");
        idle("R11 timer0 requests over user");
        step(10'b10_0001_0000, 0, '0, 0, 0, 1, 0, "R11 take timer0");
        // R7: timer1 below timer0 must wait
        step(10'b10_0011_0000, 0, '0, 0, 0, 0, 0, "R7 timer1 raise");
        idle("R7 timer1 waits");
        // memory fault preempts, 3-deep
        step(10'b10_0011_0100, 0, '0, 0, 0, 0, 0, "R6 memfault raise");
        step(10'b10_0011_0100, 0, '0, 0, 0, 1, 0, "R11 take memfault");
        idle("R11 three deep");
        step(10'b10_0011_0100, 0, '0, 0, 0, 0, 1, "R9 rti memfault");
        idle("R9 timer0 still in service");
        step(10'b10_0011_0100, 0, '0, 0, 0, 0, 1, "R9 rti timer0");
        idle("R7 timer1 now requests");
        step(10'b10_0011_0100, 0, '0, 0, 0, 1, 0, "R8 take timer1");
        step(10'b10_0011_0100, 0, '0, 0, 0, 0, 1, "R9 rti timer1");
        step(10'b10_0011_0100, 0, '0, 0, 0, 0, 1, "R9 rti user");
        step('0, 0, '0, 0, 0, 0, 1, "R9 rti empty no effect");
        // R10 stray ack
        step('0, 0, '0, 0, 0, 1, 0, "R10 stray ack");
        idle("R10 stray ack no effect");
        // R3 reserved line
        step(10'b00_0000_1000, 0, '0, 0, 0, 0, 0, "R3 reserved raise");
        idle("R3 reserved ignored");
        step('0, 0, '0, 0, 0, 1, 0, "R3 reserved ack");
        idle("R3 reserved ignored");
        // R4 mask
        step('0, 1, 10'b00_0100_0000, 0, 0, 0, 0, "R4 mask dma0");
        step(10'b00_0100_0000, 0, '0, 0, 0, 0, 0, "R4 dma0 raise");
        idle("R4 dma0 masked");
        step(10'b00_0100_0000, 0, '0, 0, 0, 1, 0, "R4 ack while masked");
        step(10'b00_0100_0000, 1, '0, 0, 0, 0, 0, "R4 unmask");
        idle("R4 dma0 now requests");
        step(10'b00_0100_0000, 0, '0, 0, 0, 1, 0, "R8 take dma0");
        step(10'b00_0100_0000, 0, '0, 0, 0, 0, 1, "R9 rti dma0");
        // R5 set+clr both: clear wins; sync still works
        step('0, 0, '0, 1, 1, 0, 0, "R5 clear wins");
        step(10'b00_0000_0001, 0, '0, 0, 0, 0, 0, "R5 sync raise");
        idle("R5 sync requests with gie off");
        // R2 rise coinciding with take
        step(10'b00_0000_0000, 0, '0, 0, 0, 1, 0, "R2 take sync");
        step(10'b00_0000_0001, 0, '0, 0, 0, 0, 1, "R2 new rise");
        step(10'b00_0000_0000, 0, '0, 0, 0, 1, 0, "R2 take again");
        step(10'b00_0000_0001, 0, '0, 0, 0, 0, 0, "R2 rise");
        step(10'b00_0000_0000, 0, '0, 0, 0, 0, 1, "R2 rti");
        step(10'b00_0000_0001, 0, '0, 0, 0, 1, 0, "R2 rise with take");
        idle("R2 still pending after take");
        step('0, 0, '0, 0, 0, 0, 1, "R9 pop");
        step('0, 0, '0, 0, 0, 0, 1, "R9 pop");

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] ln;
            ln = irq_line_i ^ (N'($urandom) & N'($urandom) & N'($urandom));
            step(ln, ($urandom % 40) == 0, N'($urandom) & N'($urandom),
                 ($urandom % 8) == 0, ($urandom % 30) == 0,
                 ($urandom % 3) == 0, ($urandom % 4) == 0, "R6 R7 R11 random");
        end

        // R1 reset again mid-traffic
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        m_reset();
        @(negedge clk);
        rst = 1'b0;
        irq_line_i = '0;
        idle("R1 reset clears state");
        idle("R1 reset clears state");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule